// File: doc/BRIEF.md
# Timer clock select prescaler

This block turns a 3-bit clock-select code into a count-enable strobe for a timer counter. The strobe is one system clock wide and lives in the system clock domain. The code chooses one of three kinds of source. The first is a stopped state. The second is the system clock itself, either undivided or divided through a shared free-running prescaler by 8, 64, 256 or 1024. The third is edges on an external timer pin, either falling or rising.

The prescaler runs in every mode, so the divide ratio can be changed without losing the phase of the shared divider. The external pin always passes through a synchronizer and an edge detector. Because of that, edges are counted whatever drives the pin, including logic of the same chip that toggles it on purpose to step the timer. The pin must change more slowly than half the system clock rate.

Top module: `tmr_clk_select`

## Requirements
- R1: With select code 3'b000 the strobe `count_en` stays low.
- R2: With select code 3'b001 `count_en` is high in every cycle.
- R3: Codes 3'b010, 3'b011, 3'b100 and 3'b101 give a strobe of period 8, 64, 256 and 1024 cycles. The strobe is high while the low 3, 6, 8 or 10 bits of the prescaler count are all ones. The count is the number of rising clock edges since reset release, modulo 1024, so the first strobe falls in the cycle after edge N-1.
- R4: With code 3'b110, a falling edge on `ext_pin` gives exactly one high cycle of `count_en`. That cycle follows the second rising clock edge after the pin change.
- R5: With code 3'b111, a rising edge on `ext_pin` gives exactly one high cycle of `count_en`, with the same latency as R4. Edges of the opposite direction give none.
- R6: The prescaler count is never cleared or held by a change of select code. After a switch between divide codes, the strobes line up with the same free-running count.
- R7: The pin synchronizer and edge detector run in every mode. Switching into an external mode while the pin is steady gives no strobe.
- R8: Reset (`rst_n` low, asynchronous) clears the prescaler count and the synchronizer flops. While reset is held, `count_en` is low for every code except 3'b001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_sel | input | 3 | Clock-select code |
| ext_pin | input | 1 | External timer pin, asynchronous |
| count_en | output | 1 | Single-cycle count-enable strobe |

## Verification
The bench builds the block with its default 10-bit prescaler and the two-stage synchronizer. With those values the divide-by-1024 tap, which uses the full counter width, is observed across more than two complete periods. Switches between divide codes are made in mid-period, to show the shared phase. The pin is toggled at several rates down to a few cycles per level, and a reset in the middle of a divide run shows that the prescaler restarts from zero.

// File: rtl/tmr_cs_pkg.sv
package tmr_cs_pkg;

  // Clock-select codes; the numeric values are the interface encoding.
  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_PIN_FALL = 3'd6,
    CS_PIN_RISE = 3'd7
  } cs_code_e;

  localparam int unsigned NUM_TAPS = 4;

  // log2 of the divide ratio for each prescaler tap (index 0 = /8).
  function automatic int unsigned tap_log2(input int unsigned idx);
    case (idx)
      0:       tap_log2 = 3;
      1:       tap_log2 = 6;
      2:       tap_log2 = 8;
      default: tap_log2 = 10;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_cs_pkg::*;
#(
  parameter int unsigned PS_WIDTH = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_TAPS-1:0] tap_o
);

  logic [PS_WIDTH-1:0] cnt_q;
  logic [PS_WIDTH-1:0] cnt_d;
  logic                cnt_en;

  // Free-running: the enable is permanently asserted.
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + PS_WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Tap i fires when the low tap_log2(i) bits are all ones.
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int unsigned SH = tap_log2(i);
    assign tap_o[i] = &cnt_q[SH-1:0];
  end

endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   pin_s;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    prev_d = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = pin_s & ~prev_q;
  assign fall_o = ~pin_s & prev_q;

endmodule

// File: rtl/tmr_clk_select.sv
module tmr_clk_select
  import tmr_cs_pkg::*;
#(
  parameter int unsigned PS_WIDTH    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cs_sel,
  input  logic       ext_pin,
  output logic       count_en
);

  logic [NUM_TAPS-1:0] tap;
  logic                pin_rise;
  logic                pin_fall;
  cs_code_e            code;

  tmr_prescaler #(.PS_WIDTH(PS_WIDTH)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tap_o (tap)
  );

  tmr_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign code = cs_code_e'(cs_sel);

  always_comb begin
    case (code)
      CS_STOP:     count_en = 1'b0;
      CS_DIV1:     count_en = 1'b1;
      CS_DIV8:     count_en = tap[0];
      CS_DIV64:    count_en = tap[1];
      CS_DIV256:   count_en = tap[2];
      CS_DIV1024:  count_en = tap[3];
      CS_PIN_FALL: count_en = pin_fall;
      CS_PIN_RISE: count_en = pin_rise;
      default:     count_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_clk_select_chk.sv
module tmr_clk_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cs_sel,
  input logic       ext_pin,
  input logic       count_en
);

  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd3);

  p_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel == 3'd0) |-> !count_en);

  p_nodiv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel == 3'd1) |-> count_en);

  p_div8_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel == 3'd2 && count_en) |=> (cs_sel != 3'd2 || !count_en));

  p_fall_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && cs_sel == 3'd6 && count_en) |-> (!$past(ext_pin, 2) && $past(ext_pin, 3)));

  p_rise_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && cs_sel == 3'd7 && count_en) |-> ($past(ext_pin, 2) && !$past(ext_pin, 3)));

  // R4 and R5: an edge strobe never lasts two cycles.
  p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel[2:1] == 2'b11 && count_en) |=> !(cs_sel[2:1] == 2'b11 && count_en));

  p_reset_quiet_r8: assert property (@(posedge clk)
    (!rst_n && cs_sel != 3'd1) |-> !count_en);

endmodule

bind tmr_clk_select tmr_clk_select_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_sel   (cs_sel),
  .ext_pin  (ext_pin),
  .count_en (count_en)
);

// File: tb/tmr_clk_select_tb.sv
module tmr_clk_select_tb;

  logic       clk;
  logic       rst_n;
  logic [2:0] cs_sel;
  logic       ext_pin;
  logic       count_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Behavioural reference state
  int ps = 0;
  bit m_s0 = 0, m_s1 = 0, m_prev = 0;
  bit in_reset = 1;

  tmr_clk_select u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_sel   (cs_sel),
    .ext_pin  (ext_pin),
    .count_en (count_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps = 0; m_s0 = 0; m_s1 = 0; m_prev = 0;
    end else begin
      ps     = (ps + 1) % 1024;
      m_prev = m_s1;
      m_s1   = m_s0;
      m_s0   = ext_pin;
    end
  end

  function automatic bit expect_en(input int sel);
    case (sel)
      0: return 1'b0;
      1: return 1'b1;
      2: return (ps % 8)    == 7;
      3: return (ps % 64)   == 63;
      4: return (ps % 256)  == 255;
      5: return (ps % 1024) == 1023;
      6: return !m_s1 && m_prev;
      default: return m_s1 && !m_prev;
    endcase
  endfunction

  function automatic string tag_of(input int sel);
    if (in_reset) return "R8";
    case (sel)
      0: return "R1";
      1: return "R2";
      2, 3, 4, 5: return "R3 R6";
      6: return "R4 R7";
      default: return "R5 R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      bit e;
      e = expect_en(int'(cs_sel));
      total++;
      if (count_en !== e) begin
        bad++;
        $display("FAIL %s: sel=%0d ps=%0d count_en=%b expected=%b",
                 tag_of(int'(cs_sel)), cs_sel, ps, count_en, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic toggle_pin(input int times, input int hold);
    for (int i = 0; i < times; i++) begin
      ext_pin = ~ext_pin;
      step(hold + (i % 3));
    end
  endtask

  initial begin
    rst_n = 1'b0; cs_sel = 3'd2; ext_pin = 1'b0;
    step(3);
    cs_sel = 3'd0; step(1);       // R8: reset quiet in stop mode too
    cs_sel = 3'd1; step(1);
    cs_sel = 3'd2;
    rst_n = 1'b1; in_reset = 0;
    step(40);                     // R3 /8 from release
    cs_sel = 3'd1; step(20);      // R2
    cs_sel = 3'd0; step(20);      // R1
    cs_sel = 3'd3; step(200);     // R3 /64
    cs_sel = 3'd2; step(13);      // R6 mid-period switches
    cs_sel = 3'd4; step(600);     // R3 /256
    cs_sel = 3'd5; step(2300);    // R3 /1024
    cs_sel = 3'd7; toggle_pin(20, 3);   // R5
    cs_sel = 3'd6; toggle_pin(20, 2);   // R4
    cs_sel = 3'd0; ext_pin = 1'b1; step(10);
    cs_sel = 3'd7; step(10);      // R7 steady high, no strobe
    cs_sel = 3'd6; step(10);
    ext_pin = 1'b0; step(10);
    cs_sel = 3'd3; step(37);
    rst_n = 1'b0; in_reset = 1; step(2);   // R8 mid-run reset
    rst_n = 1'b1; in_reset = 0; step(150); // prescaler restarted
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule